// File: doc/BRIEF.md
# Triangular Frequency Ramp Generator

This block drives the tuning word of a direct digital synthesiser so that the synthesised frequency rises and falls in a continuous triangle. The 32-bit word moves from a lower limit up to an upper limit by a programmable rising step. It then moves back down by a separately programmable falling step. At each limit it turns around by itself. The result is a repeating FMCW sweep whose two legs may have different slopes.

The word changes only on every fourth clock, paced by an internal divide-by-four prescaler. With a 1 GHz clock, a 1 ms leg therefore has 250,000 steps, and the step size is chosen as the span divided by that count. A step that would carry the word past a limit is clamped to that limit, and the direction reverses on the same update.

The word goes straight to the phase accumulator. A direction flag and a one-cycle strobe mark each update for downstream logic.

Top module: `fmcw_ramp_gen`

## Requirements
- R1: While `rst` is high or `enable` is low, each clock edge loads `freqWord` with `lowLimit`, sets `rising` to 1 and holds `updateStrobe` at 0; the prescaler restarts from zero.
- R2: With `enable` high, an update happens on every 4th clock edge, counted from the first enabled edge. `updateStrobe` is 1 in exactly the cycle that follows each update edge and is 0 otherwise.
- R3: On an update while rising, if `freqWord + incStep` is below `highLimit`, the word becomes `freqWord + incStep` and `rising` stays 1.
- R4: On an update while falling, if `freqWord - decStep` is above `lowLimit`, the word becomes `freqWord - decStep` and `rising` stays 0.
- R5: On an update while rising, if `freqWord + incStep` is at or above `highLimit` (sum taken without wrap), the word becomes exactly `highLimit` and `rising` becomes 0 on that same update.
- R6: On an update while falling, if `freqWord - decStep` is at or below `lowLimit`, the word becomes exactly `lowLimit` and `rising` becomes 1. A difference below zero also counts as at or below `lowLimit`.
- R7: Between updates, `freqWord` and `rising` hold their values whatever the limit and step inputs do. New input values act only at the next update edge.
- R8: On an update with `highLimit` below `lowLimit`, the word becomes `lowLimit` and `rising` becomes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Run the sweep; low parks the word at the lower limit |
| lowLimit | input | 32 | Lower turn-around frequency word |
| highLimit | input | 32 | Upper turn-around frequency word |
| incStep | input | 32 | Step added per update on the rising leg |
| decStep | input | 32 | Step subtracted per update on the falling leg |
| freqWord | output | 32 | Instantaneous frequency tuning word |
| rising | output | 1 | 1 while the ramp is going up |
| updateStrobe | output | 1 | One-cycle pulse after each word update |

## Verification
The bench targets exact arrival at a limit. A design that compares with a strict inequality would step once more and overshoot, instead of turning on the limit itself. A falling step larger than the word is also driven. This catches a subtractor that wraps to a huge value and sends the ramp back up from near full scale.

Limits and steps are changed midway between updates. A design that reacts at once would show the word moving off the four-clock grid. Inverted limits are also applied; a design without the guard would oscillate between the limits or stick at the upper one. Finally, the strobe count over a long run exposes a prescaler that divides by three or five.

// File: rtl/ramp_pkg.sv
package ramp_pkg;

  // Action the control path orders from the accumulator on a given edge.
  typedef struct packed {
    logic load;      // park at lower limit (reset / disabled)
    logic stepUp;    // add rising step
    logic stepDown;  // subtract falling step
    logic pinHigh;   // clamp to upper limit
    logic pinLow;    // clamp to lower limit
  } rampCmd_t;

endpackage

// File: rtl/ramp_prescaler.sv
module ramp_prescaler #(
  parameter int unsigned DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);

  generate
    if (DIV < 2) begin : g_direct
      assign tick = run;
    end else begin : g_count
      localparam int unsigned CW = $clog2(DIV);
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);

      logic [CW-1:0] phaseCnt;

      always_ff @(posedge clk) begin
        if (rst || !run) begin
          phaseCnt <= '0;
        end else if (phaseCnt == LAST) begin
          phaseCnt <= '0;
        end else begin
          phaseCnt <= phaseCnt + 1'b1;
        end
      end

      assign tick = run && (phaseCnt == LAST);

      AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (rst)
        phaseCnt <= LAST); // R2
      AST_TICK_GAP: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick); // R2
    end
  endgenerate

endmodule

// File: rtl/ramp_ctrl.sv
module ramp_ctrl
  import ramp_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         enable,
  input  logic         tick,
  input  logic [W:0]   upSum,
  input  logic [W:0]   downDiff,
  input  logic [W-1:0] lowLimit,
  input  logic [W-1:0] highLimit,
  output rampCmd_t     cmd,
  output logic         rising
);

  logic badRange;
  logic hitHigh;
  logic hitLow;
  logic nextRising;

  // Endpoint comparison on the widened sum / difference, so no wrap can hide a crossing.
  assign badRange = highLimit < lowLimit;
  assign hitHigh  = upSum >= {1'b0, highLimit};
  assign hitLow   = downDiff[W] || (downDiff[W-1:0] <= lowLimit);

  always_comb begin
    cmd        = '0;
    nextRising = rising;
    if (rst || !enable) begin
      cmd.load   = 1'b1;
      nextRising = 1'b1;
    end else if (tick) begin
      if (badRange) begin
        cmd.pinLow = 1'b1;
        nextRising = 1'b1;
      end else if (rising) begin
        if (hitHigh) begin
          cmd.pinHigh = 1'b1;
          nextRising  = 1'b0;
        end else begin
          cmd.stepUp = 1'b1;
        end
      end else begin
        if (hitLow) begin
          cmd.pinLow = 1'b1;
          nextRising = 1'b1;
        end else begin
          cmd.stepDown = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    rising <= nextRising;
  end

  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cmd.load, cmd.stepUp, cmd.stepDown, cmd.pinHigh, cmd.pinLow})); // R5
  AST_TURN_AT_TOP: assert property (@(posedge clk) disable iff (rst)
    cmd.pinHigh |=> !rising); // R5
  AST_TURN_AT_FLOOR: assert property (@(posedge clk) disable iff (rst)
    cmd.pinLow |=> rising); // R6
  AST_DIR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (enable && !tick) |=> $stable(rising)); // R7

endmodule

// File: rtl/ramp_datapath.sv
module ramp_datapath
  import ramp_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  rampCmd_t     cmd,
  input  logic [W-1:0] lowLimit,
  input  logic [W-1:0] highLimit,
  input  logic [W-1:0] incStep,
  input  logic [W-1:0] decStep,
  output logic [W-1:0] freqWord,
  output logic [W:0]   upSum,
  output logic [W:0]   downDiff
);

  logic [W-1:0] accum;

  // One extra bit: carry on the way up, borrow on the way down.
  assign upSum    = {1'b0, accum} + {1'b0, incStep};
  assign downDiff = {1'b0, accum} - {1'b0, decStep};

  always_ff @(posedge clk) begin
    if (cmd.load || cmd.pinLow) begin
      accum <= lowLimit;
    end else if (cmd.pinHigh) begin
      accum <= highLimit;
    end else if (cmd.stepUp) begin
      accum <= upSum[W-1:0];
    end else if (cmd.stepDown) begin
      accum <= downDiff[W-1:0];
    end
  end

  assign freqWord = accum;

  AST_LOAD_LOW: assert property (@(posedge clk) disable iff (rst)
    cmd.load |=> freqWord == $past(lowLimit)); // R1
  AST_STEP_UP: assert property (@(posedge clk) disable iff (rst)
    cmd.stepUp |=> freqWord == $past(freqWord) + $past(incStep)); // R3
  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (rst)
    cmd.stepDown |=> freqWord == $past(freqWord) - $past(decStep)); // R4
  AST_HOLD_WORD: assert property (@(posedge clk) disable iff (rst)
    !(cmd.load || cmd.stepUp || cmd.stepDown || cmd.pinHigh || cmd.pinLow)
      |=> $stable(freqWord)); // R7

endmodule

// File: rtl/fmcw_ramp_gen.sv
module fmcw_ramp_gen
  import ramp_pkg::*;
#(
  parameter int unsigned W   = 32,
  parameter int unsigned DIV = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         enable,
  input  logic [W-1:0] lowLimit,
  input  logic [W-1:0] highLimit,
  input  logic [W-1:0] incStep,
  input  logic [W-1:0] decStep,
  output logic [W-1:0] freqWord,
  output logic         rising,
  output logic         updateStrobe
);

  logic     tick;
  rampCmd_t cmd;
  logic [W:0] upSum;
  logic [W:0] downDiff;

  ramp_prescaler #(.DIV(DIV)) i_prescaler (
    .clk  (clk),
    .rst  (rst),
    .run  (enable),
    .tick (tick)
  );

  ramp_ctrl #(.W(W)) i_ctrl (
    .clk       (clk),
    .rst       (rst),
    .enable    (enable),
    .tick      (tick),
    .upSum     (upSum),
    .downDiff  (downDiff),
    .lowLimit  (lowLimit),
    .highLimit (highLimit),
    .cmd       (cmd),
    .rising    (rising)
  );

  ramp_datapath #(.W(W)) i_datapath (
    .clk       (clk),
    .rst       (rst),
    .cmd       (cmd),
    .lowLimit  (lowLimit),
    .highLimit (highLimit),
    .incStep   (incStep),
    .decStep   (decStep),
    .freqWord  (freqWord),
    .upSum     (upSum),
    .downDiff  (downDiff)
  );

  always_ff @(posedge clk) begin
    updateStrobe <= !rst && tick;
  end

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    updateStrobe |=> !updateStrobe); // R2
  AST_STROBE_OFF_IDLE: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !updateStrobe); // R1

endmodule

// File: tb/test_fmcw_ramp_gen.sv
module test_fmcw_ramp_gen;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enable = 1'b0;
  logic [31:0] lowLimit = 32'd100;
  logic [31:0] highLimit = 32'd1000;
  logic [31:0] incStep = 32'd300;
  logic [31:0] decStep = 32'd250;
  logic [31:0] freqWord;
  logic        rising;
  logic        updateStrobe;

  int total = 0;
  int bad = 0;
  bit checking = 1'b0;
  bit finished = 1'b0;
  string curTag = "R1";

  always #10 clk = ~clk;

  fmcw_ramp_gen i_fmcw_ramp_gen (
    .clk(clk), .rst(rst), .enable(enable),
    .lowLimit(lowLimit), .highLimit(highLimit),
    .incStep(incStep), .decStep(decStep),
    .freqWord(freqWord), .rising(rising), .updateStrobe(updateStrobe)
  );

  // Reference: next {rising, word} from the requirement text (R3..R6, R8).
  function automatic logic [32:0] refStep(logic [31:0] acc, logic rise,
                                          logic [31:0] lo, logic [31:0] hi,
                                          logic [31:0] up, logic [31:0] dn);
    longint a = longint'(acc);
    if (hi < lo) return {1'b1, lo};
    if (rise) begin
      if (a + longint'(up) >= longint'(hi)) return {1'b0, hi};
      return {1'b1, 32'(a + longint'(up))};
    end
    if (a - longint'(dn) <= longint'(lo)) return {1'b1, lo};
    return {1'b0, 32'(a - longint'(dn))};
  endfunction

  logic [31:0] mAcc;
  logic        mRise;
  logic        mStb;
  int          mCnt;

  always @(posedge clk) begin
    logic [32:0] nxt;
    if (rst || !enable) begin
      mAcc = lowLimit; mRise = 1'b1; mStb = 1'b0; mCnt = 0;
    end else begin
      mStb = (mCnt == 3);
      if (mCnt == 3) begin
        nxt = refStep(mAcc, mRise, lowLimit, highLimit, incStep, decStep);
        mRise = nxt[32]; mAcc = nxt[31:0]; mCnt = 0;
      end else begin
        mCnt = mCnt + 1;
      end
    end
  end

  task automatic check(string tag, string what, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (checking) begin
      check(curTag, "freqWord", freqWord, mAcc);
      check(curTag, "rising", rising, mRise);
      check(curTag, "updateStrobe", updateStrobe, mStb);
    end
  end

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic nextUpdate();
    do @(negedge clk); while (!updateStrobe);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    bad++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    int strobes;
    void'($urandom(32'h5eed_0042));
    cyc(2);
    checking = 1'b1;
    // R1: reset state
    check("R1", "reset word", freqWord, 100);
    check("R1", "reset rising", rising, 1);
    check("R1", "reset strobe", updateStrobe, 0);
    rst = 1'b0;
    cyc(3);
    check("R1", "disabled word", freqWord, 100);

    // R3/R5: 100 -> 400 -> 700 -> 1000 (exact arrival turns)
    curTag = "R3";
    enable = 1'b1;
    cyc(3);
    check("R2", "no strobe before 4th edge", updateStrobe, 0);
    nextUpdate(); check("R3", "first step", freqWord, 400);
    nextUpdate(); check("R3", "second step", freqWord, 700);
    curTag = "R5";
    nextUpdate(); check("R5", "exact top", freqWord, 1000);
    check("R5", "turned", rising, 0);
    curTag = "R4";
    nextUpdate(); check("R4", "down step", freqWord, 750);
    nextUpdate(); check("R4", "down step 2", freqWord, 500);

    // R7: input change between updates is invisible until next update
    curTag = "R7";
    cyc(1);
    decStep = 32'd7;
    cyc(1);
    check("R7", "hold after step change", freqWord, 500);
    nextUpdate(); check("R7", "new step at boundary", freqWord, 493);

    // R6: oversized falling step underflows -> clamp low
    curTag = "R6";
    lowLimit = 32'd5; decStep = 32'hFFFF_FFF0;
    nextUpdate(); check("R6", "underflow clamp", freqWord, 5);
    check("R6", "turned up", rising, 1);

    // R5: overshoot near full scale without wrap
    curTag = "R5";
    highLimit = 32'hFFFF_FFFF; incStep = 32'hFFFF_FFF0;
    nextUpdate(); check("R5", "no wrap", freqWord, 32'hFFFF_FFF5);
    nextUpdate(); check("R5", "clamp full scale", freqWord, 32'hFFFF_FFFF);

    // R8: inverted limits
    curTag = "R8";
    lowLimit = 32'd900; highLimit = 32'd200;
    nextUpdate(); check("R8", "inverted park", freqWord, 900);
    nextUpdate(); check("R8", "inverted stay", freqWord, 900);
    check("R8", "inverted rising", rising, 1);

    // R2: strobe count over 400 cycles
    curTag = "R2";
    lowLimit = 32'd0; highLimit = 32'd5000; incStep = 32'd13; decStep = 32'd17;
    strobes = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (updateStrobe) strobes++;
    end
    check("R2", "strobe count", strobes, 100);

    // R1: disabling parks the word again
    curTag = "R1";
    enable = 1'b0;
    cyc(2);
    check("R1", "park on disable", freqWord, 0);
    enable = 1'b1;

    // Random sweeps, checked cycle by cycle against the model
    curTag = "R3";
    for (int seg = 0; seg < 60; seg++) begin
      lowLimit  = $urandom_range(0, 100000);
      highLimit = lowLimit + $urandom_range(0, 3000);
      incStep   = $urandom_range(1, 700);
      decStep   = $urandom_range(1, 700);
      if (seg % 9 == 4) highLimit = lowLimit - 32'd1;
      if (seg % 13 == 6) enable = 1'b0;
      curTag = (seg % 9 == 4) ? "R8" : ((seg % 2 == 0) ? "R4" : "R5");
      cyc($urandom_range(2, 300));
      enable = 1'b1;
      cyc($urandom_range(1, 3));
    end

    finish();
  end

endmodule